// File: doc/BRIEF.md
# Six-Channel Shared-Period PWM Timer

This block is a PWM timer in which six output channels share one clock divider, one 16-bit up-counter and one period limit. Each channel compares the shared count against its own threshold and drives an edge-aligned pulse. Because the count and its limit are common, all channels run at the same period. Only the pulse width differs from channel to channel. Software controls the block through a simple register port. A write strobe carries an address and 16 bits of data, and a separate read address returns register contents combinationally.

Register addresses: 0 is control, with run code in bits 1:0, divider exponent in bits 4:2 and wrap flag in bit 8. Address 1 is the period limit and address 2 is the count. Addresses 8 to 13 hold the channel thresholds, and addresses 16 to 21 hold the channel output modes (2 bits each). Threshold updates are rate limited: each period accepts only the first one, and rewriting the count starts a fresh period. This gives software a way to apply a new width at once, at the cost of shortening the running period.

Top module: `pwm_timer_unit`

## Requirements
- R1: The count steps from 0 up to the active period limit and then returns to 0, so one period lasts limit+1 ticks; a limit of 0 gives a one-tick period.
- R2: The count advances only while the run code (control bits 1:0) is 01; with any other code it holds its value.
- R3: A tick occurs once every 2^e clock cycles, where e is the divider exponent in control bits 4:2 (0 to 7); the divider restarts whenever the counter is stopped or the count is written.
- R4: A control write changes the divider exponent only if the run code held before that write is 00; otherwise the exponent keeps its old value while the run code is still updated.
- R5: Within one period, only the first write to a channel threshold is accepted; later writes in the same period are dropped. A threshold read returns the last accepted value.
- R6: Any write to the count address sets the count to 0, restarts the divider and begins a new period. This re-arms threshold acceptance and loads the pending threshold and period limit. This write takes priority over a tick in the same cycle.
- R7: An accepted threshold becomes active only at the next wrap or count write. A threshold write in the same cycle as a wrap counts as the first write of the new period: it is accepted, and the threshold loaded at that wrap is the previously accepted value.
- R8: In mode 10 a channel output is high while count < active threshold and low otherwise. A threshold above the limit gives a constantly high output, and a threshold of 0 gives a constantly low output.
- R9: A channel in any mode other than 10 (including the reset value 00) drives its output low.
- R10: The wrap flag (control bit 8 and the flag output) is set when the count returns from the limit to 0. It is cleared by a control write with bit 8 set, and a wrap in the same cycle wins over the clear.
- R11: A written period limit reads back at once but governs the count only from the next wrap or count write. Its reset value is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Read data for rd_addr |
| pwm_out | output | 6 | Channel outputs, bit i is channel i |
| ovf_flag | output | 1 | Wrap flag |

## Verification
The case that needs the most care is a threshold write arriving in the same clock cycle as the count wraps. At that moment, the once-per-period acceptance rule and the period-boundary transfer act together. The bench accepts one threshold early in a period. It then times a second threshold write to land exactly on the edge where the count returns to zero. It judges the result by reading the threshold back (the second value must be accepted) and by counting high cycles over the next two periods: the first must show the earlier value and the second the later one. A count write that lands on a tick edge is also checked, since the count must read zero afterwards.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int TMR_CNT_W    = 16;
  localparam int TMR_ADDR_W   = 5;
  localparam int TMR_NUM_CH   = 6;
  localparam int TMR_PS_W     = 3;

  localparam int ADR_CTRL     = 0;
  localparam int ADR_LIMIT    = 1;
  localparam int ADR_COUNT    = 2;
  localparam int ADR_THR_BASE = 8;
  localparam int ADR_MODE_BASE = 16;

  localparam int CTRL_RUN_LO  = 0;
  localparam int CTRL_EXP_LO  = 2;
  localparam int CTRL_WRAP_B  = 8;

  typedef enum logic [1:0] {
    RUN_STOP  = 2'b00,
    RUN_GO    = 2'b01,
    RUN_RSV_A = 2'b10,
    RUN_RSV_B = 2'b11
  } run_code_e;

  typedef enum logic [1:0] {
    OUT_OFF     = 2'b00,
    OUT_RSV_A   = 2'b01,
    OUT_EDGE_HI = 2'b10,
    OUT_RSV_B   = 2'b11
  } out_mode_e;

endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] exp_sel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, lim_c;

  always_comb begin
    lim_c = ~({DIV_W{1'b1}} << exp_sel);
    tick  = run && !restart && (div_q == lim_c);
    if (!run || restart || tick) div_d = '0;
    else                         div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R3: with a divider above 1, ticks never occur on back-to-back cycles
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && exp_sel != '0 && $stable(exp_sel)) |=> !tick);

  // R2: no tick while stopped
  a_r2_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] lim_shadow,
  output logic             wrap,
  output logic             new_period
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lsh_q, lsh_d;
  logic [CNT_W-1:0] lact_q, lact_d;

  always_comb begin
    wrap       = tick && !cnt_wr && (cnt_q == lact_q);
    new_period = wrap || cnt_wr;

    cnt_d = cnt_q;
    if (cnt_wr)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;

    lsh_d  = lim_wr ? lim_wdata : lsh_q;
    lact_d = new_period ? lsh_d : lact_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lsh_q  <= '1;
      lact_q <= '1;
    end else begin
      cnt_q  <= cnt_d;
      lsh_q  <= lsh_d;
      lact_q <= lact_d;
    end
  end

  assign count      = cnt_q;
  assign lim_shadow = lsh_q;

  // R1: the count never exceeds the active limit
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lact_q);

  // R2: without a tick or a count write the count holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  // R11: the active limit only moves at a period boundary
  a_r11_limit_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !new_period |=> $stable(lact_q));

endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic             mode_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             new_period,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] thr_shadow,
  output logic [1:0]       mode,
  output logic             pwm
);
  logic [CNT_W-1:0] shd_q, shd_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             taken_q, taken_d;
  logic [1:0]       mode_q, mode_d;
  logic             accept;

  always_comb begin
    accept  = thr_wr && (!taken_q || new_period);
    shd_d   = accept ? wdata : shd_q;
    taken_d = accept || (taken_q && !new_period);
    act_d   = new_period ? shd_q : act_q;
    mode_d  = mode_wr ? wdata[1:0] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q   <= '0;
      act_q   <= '0;
      taken_q <= 1'b0;
      mode_q  <= OUT_OFF;
    end else begin
      shd_q   <= shd_d;
      act_q   <= act_d;
      taken_q <= taken_d;
      mode_q  <= mode_d;
    end
  end

  assign pwm        = (mode_q == OUT_EDGE_HI) && (count < act_q);
  assign thr_shadow = shd_q;
  assign mode       = mode_q;

  // R5: a second write in the same period leaves the shadow untouched
  a_r5_one_write_per_period: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q && thr_wr && !new_period) |=> $stable(shd_q));

  // R7: the active threshold only changes at a period boundary
  a_r7_active_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !new_period |=> $stable(act_q));

endmodule

// File: rtl/pwm_timer_unit.sv
module pwm_timer_unit
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = TMR_CNT_W,
  parameter int ADDR_W = TMR_ADDR_W,
  parameter int NUM_CH = TMR_NUM_CH,
  parameter int PS_W   = TMR_PS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              ovf_flag
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(ADR_LIMIT);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(ADR_COUNT);

  logic [1:0]      run_q, run_d;
  logic [PS_W-1:0] exp_q, exp_d;
  logic            wrapf_q, wrapf_d;

  logic ctrl_wr, lim_wr, cnt_wr;
  logic tick, wrap, new_period;
  logic [CNT_W-1:0] count, lim_shadow;

  logic [CNT_W-1:0] thr_shadow [NUM_CH];
  logic [1:0]       ch_mode    [NUM_CH];

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    lim_wr  = wr_en && (wr_addr == A_LIMIT);
    cnt_wr  = wr_en && (wr_addr == A_COUNT);
  end

  // control register next state
  always_comb begin
    run_d   = run_q;
    exp_d   = exp_q;
    wrapf_d = wrapf_q;
    if (ctrl_wr) begin
      run_d = wr_data[CTRL_RUN_LO +: 2];
      if (run_q == RUN_STOP) exp_d = wr_data[CTRL_EXP_LO +: PS_W];
      if (wr_data[CTRL_WRAP_B]) wrapf_d = 1'b0;
    end
    if (wrap) wrapf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= RUN_STOP;
      exp_q   <= '0;
      wrapf_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      exp_q   <= exp_d;
      wrapf_q <= wrapf_d;
    end
  end

  pwm_tick_div #(.PS_W(PS_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q == RUN_GO),
    .restart (cnt_wr),
    .exp_sel (exp_q),
    .tick    (tick)
  );

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt_wr     (cnt_wr),
    .lim_wr     (lim_wr),
    .lim_wdata  (wr_data),
    .count      (count),
    .lim_shadow (lim_shadow),
    .wrap       (wrap),
    .new_period (new_period)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic thr_wr_i, mode_wr_i;
    assign thr_wr_i  = wr_en && (wr_addr == ADDR_W'(ADR_THR_BASE + i));
    assign mode_wr_i = wr_en && (wr_addr == ADDR_W'(ADR_MODE_BASE + i));

    pwm_out_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_wr     (thr_wr_i),
      .mode_wr    (mode_wr_i),
      .wdata      (wr_data),
      .new_period (new_period),
      .count      (count),
      .thr_shadow (thr_shadow[i]),
      .mode       (ch_mode[i]),
      .pwm        (pwm_out[i])
    );
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) begin
      rd_data[CTRL_RUN_LO +: 2]    = run_q;
      rd_data[CTRL_EXP_LO +: PS_W] = exp_q;
      rd_data[CTRL_WRAP_B]         = wrapf_q;
    end else if (rd_addr == A_LIMIT) begin
      rd_data = lim_shadow;
    end else if (rd_addr == A_COUNT) begin
      rd_data = count;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (rd_addr == ADDR_W'(ADR_THR_BASE + i))  rd_data = thr_shadow[i];
        if (rd_addr == ADDR_W'(ADR_MODE_BASE + i)) rd_data[1:0] = ch_mode[i];
      end
    end
  end

  assign ovf_flag = wrapf_q;

  // R4: the exponent only changes after a write made while stopped
  a_r4_exp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exp_q) |-> $past(run_q == RUN_STOP && ctrl_wr));

  // R10: a wrap always leaves the flag set
  a_r10_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> wrapf_q);

  // R10: the flag only falls after a clearing control write
  a_r10_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrapf_q) |-> $past(ctrl_wr && wr_data[CTRL_WRAP_B]));

endmodule

// File: tb/pwm_timer_unit_bench.sv
module pwm_timer_unit_bench;

  localparam int CW = 16;
  localparam int AW = 5;
  localparam int NC = 6;

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_LIM  = 5'd1;
  localparam logic [AW-1:0] A_CNT  = 5'd2;
  localparam logic [AW-1:0] A_THR0 = 5'd8;
  localparam logic [AW-1:0] A_MOD0 = 5'd16;

  // {limit, threshold, mode, expected high cycles per period}
  localparam int NVEC = 8;
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd9,  16'd3,  16'd2, 16'd3},
    {16'd9,  16'd0,  16'd2, 16'd0},
    {16'd9,  16'd10, 16'd2, 16'd10},
    {16'd9,  16'd40, 16'd2, 16'd10},
    {16'd4,  16'd2,  16'd0, 16'd0},
    {16'd15, 16'd8,  16'd2, 16'd8},
    {16'd0,  16'd1,  16'd2, 16'd1},
    {16'd7,  16'd7,  16'd3, 16'd0}
  };

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] rd_data;
  logic [NC-1:0] pwm_out;
  logic          ovf_flag;

  int n_run  = 0;
  int n_fail = 0;

  pwm_timer_unit u_pwm_timer_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .ovf_flag (ovf_flag)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input int d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = CW'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int d);
    rd_addr = a;
    #1ns;
    d = int'(rd_data);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    int v;
    int hi, other;
    int cs [13];
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    rst_n   = 1'b0;
    idle(3);

    // reset state
    check("reset pwm_out", int'(pwm_out), 0);
    check("reset R10 flag", int'(ovf_flag), 0);
    rd(A_CTRL, v); check("reset R2 ctrl", v, 0);
    rd(A_LIM, v);  check("reset R11 limit", v, 16'hFFFF);
    rd(A_CNT, v);  check("reset R1 count", v, 0);
    rst_n = 1'b1;
    idle(2);

    // table walk: R1, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      int m, c, md, e;
      m  = int'(VEC[i][63:48]);
      c  = int'(VEC[i][47:32]);
      md = int'(VEC[i][31:16]);
      e  = int'(VEC[i][15:0]);
      wr(A_CTRL, 0);
      wr(A_LIM, m);
      wr(A_CNT, 0);
      wr(A_THR0, c);
      wr(A_MOD0, md);
      wr(A_CNT, 0);
      wr(A_CTRL, 1);
      hi = 0; other = 0;
      for (int k = 0; k <= m; k++) begin
        if (pwm_out[0]) hi++;
        if (pwm_out[NC-1:1] != '0) other++;
        @(negedge clk);
      end
      check($sformatf("R8 vec%0d high cycles", i), hi, e);
      check($sformatf("R9 vec%0d idle channels", i), other, 0);
    end

    // R5 / R6: second write dropped, count write re-arms
    wr(A_CTRL, 0);
    wr(A_CNT, 0);
    wr(A_THR0, 5);
    wr(A_THR0, 9);
    rd(A_THR0, v); check("R5 second write dropped", v, 5);
    wr(A_CNT, 0);
    wr(A_THR0, 9);
    rd(A_THR0, v); check("R6 acceptance re-armed", v, 9);

    // R6: count write restarts while running, wins over tick
    wr(A_LIM, 7);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(3);
    rd(A_CNT, v); check("R1 count advancing", v, 3);
    wr(A_CNT, 0);
    rd(A_CNT, v); check("R6 count write clears", v, 0);
    idle(1);
    rd(A_CNT, v); check("R6 count resumes", v, 1);

    // R3 / R4: divide by 4, exponent locked while running
    wr(A_CTRL, 0);
    wr(A_LIM, 100);
    wr(A_CNT, 0);
    wr(A_CTRL, (2 << 2) | 1);
    idle(3);
    rd(A_CNT, v); check("R3 no tick before 4 cycles", v, 0);
    idle(1);
    rd(A_CNT, v); check("R3 first tick after 4 cycles", v, 1);
    idle(4);
    rd(A_CNT, v); check("R3 second tick", v, 2);
    wr(A_CTRL, 1);
    rd(A_CTRL, v); check("R4 exponent kept while running", (v >> 2) & 7, 2);
    wr(A_CTRL, 0);
    rd(A_CTRL, v); check("R4 exponent kept on stopping write", (v >> 2) & 7, 2);
    wr(A_CTRL, 1);
    rd(A_CTRL, v); check("R4 exponent written while stopped", (v >> 2) & 7, 0);
    idle(2);
    wr(A_CTRL, 2);
    rd(A_CNT, hi);
    idle(3);
    rd(A_CNT, v); check("R2 reserved run code holds count", v, hi);

    // R11 / R1: new limit applied at the wrap
    wr(A_CTRL, 0);
    wr(A_LIM, 3);
    wr(A_CNT, 0);
    wr(A_LIM, 7);
    rd(A_LIM, v); check("R11 limit reads back", v, 7);
    wr(A_CTRL, 1);
    for (int k = 0; k < 13; k++) begin
      rd(A_CNT, cs[k]);
      @(negedge clk);
    end
    check("R11 old limit reached", cs[3], 3);
    check("R11 wrap at old limit", cs[4], 0);
    check("R11 new limit reached", cs[11], 7);
    check("R1 wrap at new limit", cs[12], 0);

    // R10: flag set by wrap, cleared only by write-1
    check("R10 flag set by wrap", int'(ovf_flag), 1);
    wr(A_CTRL, 0);
    check("R10 flag kept without clear bit", int'(ovf_flag), 1);
    wr(A_CTRL, 1 << 8);
    check("R10 flag cleared", int'(ovf_flag), 0);

    // R7: threshold write landing on the wrap edge
    wr(A_LIM, 3);
    wr(A_CNT, 0);
    wr(A_MOD0, 2);
    wr(A_THR0, 0);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    wr(A_THR0, 1);
    rd(A_THR0, v); check("R5 first write of period", v, 1);
    idle(2);
    wr(A_THR0, 2);
    rd(A_THR0, v); check("R7 write on wrap accepted", v, 2);
    hi = 0;
    for (int k = 0; k < 4; k++) begin
      if (pwm_out[0]) hi++;
      @(negedge clk);
    end
    check("R7 period after wrap uses earlier value", hi, 1);
    hi = 0;
    for (int k = 0; k < 4; k++) begin
      if (pwm_out[0]) hi++;
      @(negedge clk);
    end
    check("R7 following period uses wrap-edge value", hi, 2);

    finish_up();
  end

endmodule